// File: doc/BRIEF.md
# Single-Wire Return-to-One Slave Interface

This block is the device end of a one-pin, open-drain serial link. The host owns the bus idle level (high) and opens every transfer with a command byte. Each bit is a return-to-one frame. A frame opens with a falling edge. The line is then low for a 0 or high for a 1 during the data window. It goes back high before the frame ends. The block times everything with counters on its system clock. All limits are parameters given in clock cycles. At 5 kbit/s a frame is at least 200 µs long, so the parameters are sized to accept frames of that length.

After a command byte, the block either takes in one more byte and writes it to an external register file, or it reads one register from that file and sends it back, driving the line only low. A long low level is a break. A break cancels whatever is in progress. The block then waits for the line to rest high before it accepts a new command. The register file sits outside the block and is reached through an address, a write-data bus, a write strobe and a read-data bus.

Top module: `owrto_slave`

## Requirements
- R1: While reset is held and right after it, `line_oe` is 0 and `reg_we` is 0.
- R2: A received bit is the synchronised line level taken `SAMPLE_CLKS` cycles after its falling edge: high is 1, low is 0. Bytes arrive least significant bit first.
- R3: A command byte with bit 7 = 1 is a write. Bits 6..0 are the address. The next eight bits form the data byte, and the block then gives exactly one single-cycle `reg_we` pulse with `reg_addr` = address and `reg_wdata` = data.
- R4: A command byte with bit 7 = 0 is a read. No write pulse follows. After `TURN_CLKS` cycles the block sends `reg_rdata` at `reg_addr`, least significant bit first.
- R5: Each transmitted frame lasts `TX_CYCLE_CLKS`. `line_oe` is 1 for the first `TX_LOW_CLKS` cycles. For a 0 bit it stays 1 until `TX_ZERO_CLKS`. `line_oe` is 1 only while a reply is being sent, and never for more than `TX_ZERO_CLKS` cycles in a row.
- R6: A low level of `BREAK_CLKS` cycles or longer is a break. It discards any partial command byte or transmission, and a later complete command is decoded normally.
- R7: After a break the line must stay high for `RECOV_CLKS` cycles in a row. A falling edge seen before then is not taken as a bit and restarts the wait.
- R8: A write is carried out only after all eight data bits. A break after fewer than eight data bits gives no `reg_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared serial line (asynchronous) |
| line_oe | output | 1 | 1 pulls the line low; 0 releases it |
| reg_addr | output | 7 | Register address from the last command |
| reg_wdata | output | 8 | Data byte for a register write |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The block sees a host falling edge two or three cycles late because of the synchroniser. Its bit sample is taken `SAMPLE_CLKS` cycles after that, so the host holds each data level from 10 to 70 cycles into a 100-cycle frame, and the sample always lands inside that window. `reg_we` rises a few cycles after the eighth data sample. A monitor counts and captures the pulse, and the bench checks the captured values only after the whole frame has ended. A reply starts `TURN_CLKS` plus a few cycles after the last command sample. The bench finds each reply edge on the line, checks that the line is low 5 cycles later, and reads the bit 30 cycles after the edge, halfway between the end of the start low and the end of a 0 bit.

// File: rtl/owrto_pkg.sv
package owrto_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_DATA,
        ST_TURN,
        ST_TX,
        ST_BRK,
        ST_RECOV
    } st_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.wr   = b[BYTE_W-1];
        c.addr = b[ADDR_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/owrto_line_mon.sv
module owrto_line_mon #(
    parameter int BREAK_CLKS = 19000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_hi,
    output logic fall,
    output logic brk
);
    localparam int CW = $clog2(BREAK_CLKS + 1);
    localparam logic [CW-1:0] BRK_LAST = CW'(BREAK_CLKS - 1);
    localparam logic [CW-1:0] BRK_SAT  = CW'(BREAK_CLKS);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            prev_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], line_in};
            prev_q <= sync_q[1];
            if (sync_q[1])
                low_cnt <= '0;
            else if (low_cnt != BRK_SAT)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign line_hi = sync_q[1];
    assign fall    = prev_q & ~sync_q[1];
    assign brk     = ~sync_q[1] && (low_cnt == BRK_LAST);

    // R6
    brk_single_chk: assert property (@(posedge clk) disable iff (rst)
        brk |=> !brk);

endmodule

// File: rtl/owrto_rx.sv
module owrto_rx #(
    parameter int SAMPLE_CLKS = 6000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       line_hi,
    input  logic                       fall,
    output logic                       byte_done,
    output logic [owrto_pkg::BYTE_W-1:0] data
);
    localparam int TW = $clog2(SAMPLE_CLKS + 1);
    localparam logic [TW-1:0] SMP_LAST = TW'(SAMPLE_CLKS - 1);

    logic          armed;
    logic [TW-1:0] tmr;
    logic [2:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            tmr       <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
            data      <= '0;
        end else if (!en) begin
            armed     <= 1'b0;
            tmr       <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!armed) begin
                if (fall) begin
                    armed <= 1'b1;
                    tmr   <= '0;
                end
            end else if (tmr == SMP_LAST) begin
                armed     <= 1'b0;
                data      <= {line_hi, data[owrto_pkg::BYTE_W-1:1]};
                cnt       <= cnt + 1'b1;
                byte_done <= (cnt == 3'd7);
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    // R8
    done_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(en));

endmodule

// File: rtl/owrto_tx.sv
module owrto_tx #(
    parameter int TX_LOW_CLKS   = 3000,
    parameter int TX_ZERO_CLKS  = 10000,
    parameter int TX_CYCLE_CLKS = 20000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         abort,
    input  logic                         start,
    input  logic [owrto_pkg::BYTE_W-1:0] data,
    output logic                         oe,
    output logic                         done
);
    localparam int TW = $clog2(TX_CYCLE_CLKS + 1);
    localparam logic [TW-1:0] LOW_T    = TW'(TX_LOW_CLKS);
    localparam logic [TW-1:0] ZERO_T   = TW'(TX_ZERO_CLKS);
    localparam logic [TW-1:0] CYC_LAST = TW'(TX_CYCLE_CLKS - 1);

    logic                         busy;
    logic [TW-1:0]                tmr;
    logic [2:0]                   idx;
    logic [owrto_pkg::BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            tmr   <= '0;
            idx   <= '0;
            done  <= 1'b0;
            shreg <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            tmr  <= '0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                tmr   <= '0;
                idx   <= '0;
                shreg <= data;
            end else if (busy) begin
                if (tmr == CYC_LAST) begin
                    tmr   <= '0;
                    shreg <= {1'b0, shreg[owrto_pkg::BYTE_W-1:1]};
                    idx   <= idx + 1'b1;
                    if (idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    assign oe = busy && ((tmr < LOW_T) || (!shreg[0] && (tmr < ZERO_T)));

endmodule

// File: rtl/owrto_slave.sv
module owrto_slave #(
    parameter int SAMPLE_CLKS   = 6000,
    parameter int BREAK_CLKS    = 19000,
    parameter int RECOV_CLKS    = 4000,
    parameter int TURN_CLKS     = 5000,
    parameter int TX_LOW_CLKS   = 3000,
    parameter int TX_ZERO_CLKS  = 10000,
    parameter int TX_CYCLE_CLKS = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       line_oe,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    import owrto_pkg::*;

    localparam int WAIT_MAX = (TURN_CLKS > RECOV_CLKS) ? TURN_CLKS : RECOV_CLKS;
    localparam int WW = $clog2(WAIT_MAX + 1);
    localparam logic [WW-1:0] TURN_LAST  = WW'(TURN_CLKS - 1);
    localparam logic [WW-1:0] RECOV_LAST = WW'(RECOV_CLKS - 1);
    localparam int RW = $clog2(TX_ZERO_CLKS + 2);
    localparam logic [RW-1:0] RUN_SAT = RW'(TX_ZERO_CLKS + 1);

    st_e               state;
    cmd_t              cmd_q;
    logic [WW-1:0]     wt;
    logic              tx_start;
    logic              line_hi, fall, brk;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_oe, tx_done;
    logic              rx_en;

    assign rx_en = (state == ST_CMD) || (state == ST_DATA);

    owrto_line_mon #(.BREAK_CLKS(BREAK_CLKS)) mon_i (
        .clk(clk), .rst(rst), .line_in(line_in),
        .line_hi(line_hi), .fall(fall), .brk(brk)
    );

    owrto_rx #(.SAMPLE_CLKS(SAMPLE_CLKS)) rx_i (
        .clk(clk), .rst(rst), .en(rx_en), .line_hi(line_hi), .fall(fall),
        .byte_done(rx_done), .data(rx_byte)
    );

    owrto_tx #(
        .TX_LOW_CLKS(TX_LOW_CLKS), .TX_ZERO_CLKS(TX_ZERO_CLKS),
        .TX_CYCLE_CLKS(TX_CYCLE_CLKS)
    ) tx_i (
        .clk(clk), .rst(rst), .abort(brk), .start(tx_start), .data(reg_rdata),
        .oe(tx_oe), .done(tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CMD;
            cmd_q     <= '0;
            wt        <= '0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
            tx_start  <= 1'b0;
        end else begin
            reg_we   <= 1'b0;
            tx_start <= 1'b0;
            if (brk) begin
                state <= ST_BRK;
            end else begin
                case (state)
                    ST_CMD: if (rx_done) begin
                        cmd_q <= decode_cmd(rx_byte);
                        wt    <= '0;
                        state <= decode_cmd(rx_byte).wr ? ST_DATA : ST_TURN;
                    end
                    ST_DATA: if (rx_done) begin
                        reg_wdata <= rx_byte;
                        reg_we    <= 1'b1;
                        state     <= ST_CMD;
                    end
                    ST_TURN: if (wt == TURN_LAST) begin
                        tx_start <= 1'b1;
                        state    <= ST_TX;
                    end else begin
                        wt <= wt + 1'b1;
                    end
                    ST_TX: if (tx_done) state <= ST_CMD;
                    ST_BRK: if (line_hi) begin
                        wt    <= '0;
                        state <= ST_RECOV;
                    end
                    ST_RECOV: if (!line_hi) begin
                        state <= ST_BRK;
                    end else if (wt == RECOV_LAST) begin
                        state <= ST_CMD;
                    end else begin
                        wt <= wt + 1'b1;
                    end
                    default: state <= ST_CMD;
                endcase
            end
        end
    end

    assign line_oe  = tx_oe;
    assign reg_addr = cmd_q.addr;

    // Length of the current low-drive run, for the R5 bound
    logic [RW-1:0] oe_run;
    always_ff @(posedge clk) begin
        if (rst || !line_oe)
            oe_run <= '0;
        else if (oe_run != RUN_SAT)
            oe_run <= oe_run + 1'b1;
    end

    // R5
    oe_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> (state == ST_TX));

    // R5
    oe_run_chk: assert property (@(posedge clk) disable iff (rst)
        oe_run <= RW'(TX_ZERO_CLKS));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R3
    we_from_data_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ($past(state) == ST_DATA));

    // R4
    no_we_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX) |-> !reg_we);

    // R6
    brk_abort_chk: assert property (@(posedge clk) disable iff (rst)
        brk |=> ((state == ST_BRK) && !reg_we));

endmodule

// File: tb/owrto_slave_tb_top.sv
module owrto_slave_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_low = 1'b0;
    logic       line_w;
    logic       line_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic [7:0] mem [0:127];

    int checks = 0;
    int fails = 0;
    int we_count = 0;
    logic [6:0] cap_addr;
    logic [7:0] cap_data;
    bit   done_flag = 0;

    always #5 clk = ~clk;

    assign line_w    = ~(host_low | line_oe);
    assign reg_rdata = mem[reg_addr];

    owrto_slave #(
        .SAMPLE_CLKS(40), .BREAK_CLKS(300), .RECOV_CLKS(50), .TURN_CLKS(80),
        .TX_LOW_CLKS(10), .TX_ZERO_CLKS(50), .TX_CYCLE_CLKS(100)
    ) dut_i (
        .clk(clk), .rst(rst), .line_in(line_w), .line_oe(line_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst && reg_we) begin
            we_count <= we_count + 1;
            cap_addr <= reg_addr;
            cap_data <= reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic host_bit(input bit b);
        @(negedge clk); host_low = 1'b1;
        repeat (10) @(negedge clk);
        if (b) host_low = 1'b0;
        repeat (60) @(negedge clk);
        host_low = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_bit(v[i]);
    endtask

    task automatic host_break();
        @(negedge clk); host_low = 1'b1;
        repeat (400) @(negedge clk);
        host_low = 1'b0;
        repeat (70) @(negedge clk);
    endtask

    task automatic host_read(output logic [7:0] v, output bit low_ok, output bit got);
        logic prev;
        v = '0; low_ok = 1; got = 1;
        for (int i = 0; i < 8; i++) begin
            int t = 0;
            prev = line_w;
            forever begin
                @(negedge clk);
                t++;
                if (prev && !line_w) break;
                prev = line_w;
                if (t > 2000) begin got = 0; break; end
            end
            if (!got) return;
            repeat (5) @(negedge clk);
            if (line_w) low_ok = 0;
            repeat (25) @(negedge clk);
            v[i] = line_w;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(line_oe == 1'b0, "R1 line_oe after reset", line_oe, 0);
        check(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] d);
        int base;
        host_break();
        base = we_count;
        host_byte({1'b1, a});
        host_byte(d);
        repeat (20) @(negedge clk);
        check(we_count == base + 1, "R3 one write pulse", we_count - base, 1);
        check(cap_addr == a, "R3 write address", cap_addr, a);
        check(cap_data == d, "R2 R3 write data LSB first", cap_data, d);
    endtask

    task automatic t_read(input logic [6:0] a);
        logic [7:0] v; bit lo, got; int base;
        host_break();
        base = we_count;
        host_byte({1'b0, a});
        host_read(v, lo, got);
        check(got, "R4 reply arrived", got, 1);
        check(v == mem[a], "R4 read byte", v, mem[a]);
        check(lo, "R5 start low on each reply bit", lo, 1);
        check(we_count == base, "R4 no write on read", we_count - base, 0);
        repeat (100) @(negedge clk);
        check(line_oe == 1'b0, "R5 line released after reply", line_oe, 0);
    endtask

    task automatic t_abort_cmd();
        int base;
        host_break();
        base = we_count;
        host_bit(1'b1); host_bit(1'b0); host_bit(1'b1);
        host_break();
        host_byte({1'b1, 7'h33});
        host_byte(8'h5C);
        repeat (20) @(negedge clk);
        check(we_count == base + 1, "R6 one write after aborted byte", we_count - base, 1);
        check(cap_addr == 7'h33, "R6 address after break", cap_addr, 7'h33);
        check(cap_data == 8'h5C, "R6 data after break", cap_data, 8'h5C);
    endtask

    task automatic t_abort_data();
        int base;
        host_break();
        base = we_count;
        host_byte({1'b1, 7'h44});
        for (int i = 0; i < 4; i++) host_bit(i[0]);
        host_break();
        repeat (20) @(negedge clk);
        check(we_count == base, "R8 no write on partial data", we_count - base, 0);
    endtask

    task automatic t_recov();
        int base;
        @(negedge clk); host_low = 1'b1;
        repeat (400) @(negedge clk);
        host_low = 1'b0;
        repeat (10) @(negedge clk);
        host_low = 1'b1;
        repeat (10) @(negedge clk);
        host_low = 1'b0;
        repeat (80) @(negedge clk);
        base = we_count;
        host_byte({1'b1, 7'h0F});
        host_byte(8'hC3);
        repeat (20) @(negedge clk);
        check(we_count == base + 1, "R7 write after recovery", we_count - base, 1);
        check(cap_addr == 7'h0F, "R7 address not shifted", cap_addr, 7'h0F);
        check(cap_data == 8'hC3, "R7 data not shifted", cap_data, 8'hC3);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
        mem[7'h2A] = 8'h6C;
        mem[7'h7F] = 8'h81;
        mem[7'h00] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write(7'h15, 8'hA5);
        t_write(7'h7F, 8'h01);
        t_write(7'h00, 8'h80);
        t_read(7'h2A);
        t_read(7'h7F);
        t_read(7'h00);
        t_abort_cmd();
        t_abort_data();
        t_recov();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        finish_up();
    end

endmodule